// File: doc/BRIEF.md
# Two-Pin Control Port with Change Interrupt

This block gives a host two general-purpose control pins that it manages through register writes. Each pin can drive a fixed high or low level. A mode bit can release both pins to high impedance so that outside logic can drive them as inputs. A read-only status word reports the synchronized levels of both pins, alongside a vector of other status bits that the block takes in from outside.

Pin 1 has a second role. When interrupt mode is on, it becomes an active-low interrupt request. The request fires whenever any bit of the status word changes, so the host does not need to poll. A sticky pending flag holds the request until the host reads the status word.

The pad cells and the host bus protocol are not part of this block. The pins appear as separate output-enable, output-data and input-level vectors. The host sees a write port with an enable, an address and data, and a read port with an enable, an address and data.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset both output enables are 0, both output data bits are 0, the level register (address 0) reads 0, and the mode register (address 1) reads 1: high impedance on, interrupt mode off. The pending flag is clear.
- R2: Writing address 0 stores `wr_data[1:0]` as the pin levels. When interrupt mode is off, `pin_do` equals the stored levels from the second clock edge after the write onward. The value reads back from address 0.
- R3: Mode register bit 0 selects high impedance. When it is 1 and interrupt mode is off, `pin_oe` is 2'b00. When it is 0, `pin_oe` is 2'b11. The change is seen from the second clock edge after the write.
- R4: A read of address 2 returns the status word `{ext_status, pin1_level, pin0_level}` on `rd_data` after the clock edge at which `rd_en` is sampled. The pin levels come through a two-stage synchronizer.
- R5: A change in any bit of the status word from one cycle to the next sets the pending flag. This covers both pins and every `ext_status` bit.
- R6: The pending flag stays set until a read of address 2. Reads of other addresses and idle cycles leave it set.
- R7: If a status change happens in the same cycle as a read of address 2, the pending flag stays set.
- R8: When mode register bit 1 (interrupt mode) is 1, pin 1 is driven (`pin_oe[1]`=1) with `pin_do[1]` = NOT pending, one edge after the flag. Pin 0 keeps its normal setting. When interrupt mode is off, pin 1 returns to its level and mode settings.
- R9: While interrupt mode is on, status bit 1 (the pin 1 level) reads 0. Toggling the pin 1 input does not set the pending flag.
- R10: Writes to address 2 or address 3 change no register. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 level, 1 mode) |
| wr_data | input | 2 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address (0 level, 1 mode, 2 status, 3 unused) |
| rd_data | output | EXT_W+2 | Registered read data |
| ext_status | input | EXT_W | Other status bits, synchronous to clk |
| pin_di | input | 2 | Levels seen at the two pins |
| pin_oe | output | 2 | Registered output enables |
| pin_do | output | 2 | Registered output data; pin 1 carries the active-low interrupt in interrupt mode |

## Verification
The bench sweeps all four level patterns with drive on and off, which separates output data from output enable. It reads the status word for every pin input pattern with interrupt mode both off and on, which exposes synchronization and masking of bit 1. Each of the eight status bits is toggled alone with the flag cleared, so a missing bit in the change compare is caught, and pin 1 must stay silent. The flag is then kept across idle cycles and reads of other addresses, cleared by a status read, and kept by a change that coincides with that read.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPIN   = 2;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL = 2'd0,
    A_MODE  = 2'd1,
    A_STAT  = 2'd2,
    A_SPARE = 2'd3
  } gpio_addr_e;

  typedef struct packed {
    logic irq_en;
    logic hiz;
  } gpio_mode_t;

  // pin levels as the status word reports them; pin 1 hidden in interrupt mode
  function automatic logic [NPIN-1:0] pins_seen(logic [NPIN-1:0] sync, logic irq_en);
    return {sync[1] & ~irq_en, sync[0]};
  endfunction

  function automatic logic [NPIN-1:0] drive_oe(gpio_mode_t m);
    return {m.irq_en | ~m.hiz, ~m.hiz};
  endfunction

  function automatic logic [NPIN-1:0] drive_do(gpio_mode_t m, logic [NPIN-1:0] lvl, logic pend);
    return {m.irq_en ? ~pend : lvl[1], lvl[0]};
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [NPIN-1:0]      wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [STAT_W-1:0]    status_word,
  output logic [NPIN-1:0]      level,
  output gpio_mode_t           mode,
  output logic [STAT_W-1:0]    rd_data,
  output logic                 status_rd
);
  logic [NPIN-1:0]   level_q;
  gpio_mode_t        mode_q;
  logic [STAT_W-1:0] rd_q;
  logic [STAT_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      mode_q  <= '{irq_en: 1'b0, hiz: 1'b1};
    end else if (wr_en) begin
      if (wr_addr == A_LEVEL) level_q <= wr_data;
      if (wr_addr == A_MODE)  mode_q  <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      A_LEVEL: rd_mux = STAT_W'(level_q);
      A_MODE:  rd_mux = STAT_W'(mode_q);
      A_STAT:  rd_mux = status_word;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_en)  rd_q <= rd_mux;
  end

  assign status_rd = rd_en && (rd_addr == A_STAT);
  assign level     = level_q;
  assign mode      = mode_q;
  assign rd_data   = rd_q;
endmodule

// File: rtl/gpio_chg.sv
module gpio_chg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_word,
  input  logic         status_rd,
  output logic         change_evt,
  output logic         pend
);
  logic [W-1:0] prev_q;
  logic         primed_q;
  logic         pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      prev_q   <= status_word;
      primed_q <= 1'b1;
      pend_q   <= change_evt | (pend_q & ~status_rd);
    end
  end

  assign change_evt = primed_q && (status_word != prev_q);
  assign pend       = pend_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int EXT_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [1:0]            wr_data,
  input  logic                  rd_en,
  input  logic [1:0]            rd_addr,
  output logic [EXT_W+1:0]      rd_data,
  input  logic [EXT_W-1:0]      ext_status,
  input  logic [1:0]            pin_di,
  output logic [1:0]            pin_oe,
  output logic [1:0]            pin_do
);
  localparam int STAT_W = EXT_W + NPIN;

  logic [NPIN-1:0]   pin_sync;
  logic [NPIN-1:0]   level;
  gpio_mode_t        mode;
  logic [STAT_W-1:0] status_word;
  logic              status_rd;
  logic              change_evt;
  logic              pend;
  logic              irq_en;
  logic              hiz;
  logic [NPIN-1:0]   oe_q;
  logic [NPIN-1:0]   do_q;

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_di), .q(pin_sync)
  );

  assign irq_en      = mode.irq_en;
  assign hiz         = mode.hiz;
  assign status_word = {ext_status, pins_seen(pin_sync, irq_en)};

  gpio_regs #(.STAT_W(STAT_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .status_word(status_word),
    .level(level), .mode(mode),
    .rd_data(rd_data), .status_rd(status_rd)
  );

  gpio_chg #(.W(STAT_W)) u_chg (
    .clk(clk), .rst_n(rst_n),
    .status_word(status_word), .status_rd(status_rd),
    .change_evt(change_evt), .pend(pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
      do_q <= '0;
    end else begin
      oe_q <= drive_oe(mode);
      do_q <= drive_do(mode, level, pend);
    end
  end

  assign pin_oe = oe_q;
  assign pin_do = do_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       change_evt,
  input logic       status_rd,
  input logic       pend,
  input logic       irq_en,
  input logic       hiz,
  input logic [1:0] level,
  input logic [1:0] pin_oe,
  input logic [1:0] pin_do
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (pin_oe == 2'b00));

  assert_level_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> (pin_do == $past(level)));

  assert_hiz_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hiz && !irq_en) |=> (pin_oe == 2'b00));

  assert_change_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    change_evt |=> pend);

  assert_pend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !status_rd) |=> pend);

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !change_evt) |=> !pend);

  assert_coincide_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && change_evt) |=> pend);

  assert_irq_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en |=> (pin_oe[1] && (pin_do[1] == !$past(pend))));
endmodule

bind gpio_irq_port gpio_irq_port_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .change_evt(change_evt), .status_rd(status_rd), .pend(pend),
  .irq_en(irq_en), .hiz(hiz), .level(level),
  .pin_oe(pin_oe), .pin_do(pin_do)
);

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int EXT_W = 6;
  localparam int SW    = EXT_W + 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [1:0]    wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = '0;
  logic [SW-1:0] rd_data;
  logic [EXT_W-1:0] ext_status = '0;
  logic [1:0]    pin_di = '0;
  logic [1:0]    pin_oe;
  logic [1:0]    pin_do;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_port #(.EXT_W(EXT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ext_status(ext_status), .pin_di(pin_di),
    .pin_oe(pin_oe), .pin_do(pin_do)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [SW-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    d = rd_data;
  endtask

  function automatic logic [SW-1:0] exp_status(logic [EXT_W-1:0] e, logic [1:0] p, logic irq);
    return (SW'(e) << 2) | SW'(irq ? 2'b00 : p[1]) << 1 | SW'(p[0]);
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] d;
    logic exp_pend;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 oe", pin_oe, 0);
    check("R1 do", pin_do, 0);
    rd(2'd0, d); check("R1 level reg", d, 0);
    rd(2'd1, d); check("R1 mode reg", d, 1);

    // R2/R3 level and drive sweep
    wr(2'd1, 2'b00); idle(1);
    check("R3 drive on", pin_oe, 2'b11);
    for (int lv = 0; lv < 4; lv++) begin
      wr(2'd0, 2'(lv)); idle(1);
      check("R2 pin_do", pin_do, lv);
      rd(2'd0, d); check("R2 readback", d, lv);
      wr(2'd1, 2'b01); idle(1);
      check("R3 hiz", pin_oe, 2'b00);
      wr(2'd1, 2'b00); idle(1);
      check("R3 drive", pin_oe, 2'b11);
    end
    wr(2'd1, 2'b01);

    // R4/R9 status readback
    for (int irq = 0; irq < 2; irq++) begin
      wr(2'd1, {1'(irq), 1'b1});
      for (int p = 0; p < 4; p++) begin
        pin_di = 2'(p);
        ext_status = EXT_W'(p * 11 + irq * 5 + 1);
        idle(3);
        rd(2'd2, d);
        check(irq ? "R9 masked status" : "R4 status", d,
              exp_status(ext_status, pin_di, 1'(irq)));
      end
    end

    // R5/R9 single-bit change sweep in interrupt mode
    for (int b = 0; b < SW; b++) begin
      rd(2'd2, d); idle(3);
      check("R8 irq idle high", pin_do[1], 1);
      check("R8 irq pin driven", pin_oe, 2'b10);
      if (b >= 2) ext_status = ext_status ^ EXT_W'(1 << (b - 2));
      else        pin_di = pin_di ^ 2'(1 << b);
      idle(5);
      exp_pend = (b != 1);
      check(b == 1 ? "R9 pin1 no irq" : "R5 change irq", pin_do[1], !exp_pend);
    end

    // R6 sticky pending
    rd(2'd2, d); idle(3);
    ext_status = ext_status ^ 6'h01; idle(4);
    check("R5 pend set", pin_do[1], 0);
    idle(20);
    rd(2'd0, d); rd(2'd1, d); rd(2'd3, d); idle(2);
    check("R6 sticky", pin_do[1], 0);
    rd(2'd2, d); idle(2);
    check("R6 cleared by status read", pin_do[1], 1);

    // R7 change coinciding with status read
    ext_status = ext_status ^ 6'h04; idle(4);
    check("R7 pend set", pin_do[1], 0);
    rd_en = 1'b1; rd_addr = 2'd2; ext_status = ext_status ^ 6'h08;
    @(posedge clk); #1;
    rd_en = 1'b0;
    idle(2);
    check("R7 kept by coinciding change", pin_do[1], 0);
    rd(2'd2, d); idle(2);
    check("R7 later read clears", pin_do[1], 1);

    // R8 leave interrupt mode
    wr(2'd0, 2'b01);
    wr(2'd1, 2'b00); idle(2);
    check("R8 oe restored", pin_oe, 2'b11);
    check("R8 do restored", pin_do, 2'b01);

    // R10 ignored writes
    wr(2'd2, 2'b11);
    wr(2'd3, 2'b11);
    rd(2'd0, d); check("R10 level kept", d, 2'b01);
    rd(2'd1, d); check("R10 mode kept", d, 2'b00);
    rd(2'd3, d); check("R10 spare reads 0", d, 0);
    idle(3);
    rd(2'd2, d); check("R10 status", d, exp_status(ext_status, pin_di, 1'b0));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule